// File: doc/BRIEF.md
# Clear-On-Read Interrupt Aggregator

This block gathers the interrupt sources of a device controller into one 32-bit source word and drives a single interrupt line towards a processor. Three device events (bus reset, receive error and resume) arrive as single-cycle pulses and are held in sticky flags. Sixteen per-endpoint summary lines arrive as levels from the endpoint blocks and are shown in the source word as they are, without being held.

Each source bit has an enable bit in a mask register. The interrupt line is high while any source bit and its enable bit are both set. The processor reaches the two registers through a plain read/write port. Reading the source word returns its contents and clears the sticky device flags in the same access. A device event that lands in the very cycle of that clearing read is kept as pending, so no event is lost to the clear.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the sticky device flags and the mask register are all zero, `irq_o` is low and `reg_rdata_o` is zero.
- R2: A one-cycle pulse on `dev_evt_i[k]` sets source bit 16+k (k=0 bus reset, k=1 receive error, k=2 resume) at the next clock edge, and the bit stays set until a clearing read.
- R3: A read (`reg_rd_i` high) at address 0 loads `reg_rdata_o` at the next edge with bits 15:0 equal to `ep_irq_i` in the read cycle, bits 18:16 equal to the sticky flags before that edge, and all other bits, including 31 and 30, zero. `reg_rdata_o` holds its value until the next read.
- R4: A read at address 0 clears every sticky device flag that has no event in the read cycle, so a second read returns zero in bits 18:16.
- R5: A device event in the same cycle as a clearing read does not appear in that read's data and is set after the clear, so the next read returns it.
- R6: Endpoint bits 15:0 are not held: once `ep_irq_i[n]` falls, a later read shows bit n as zero.
- R7: A write (`reg_wr_i` high) at address 1 loads the mask from `reg_wdata_i`, keeping only bits 18:0. A read at address 1 returns the mask with all other bits zero. The mask changes on no other cycle.
- R8: `irq_o` is high exactly when some bit of the source word and the same bit of the mask are both 1. An endpoint level reaches `irq_o` in the same cycle, without a clock edge.
- R9: A source whose mask bit is 0 is still latched and readable but does not raise `irq_o`.
- R10: A write at address 0 and a read at address 1 leave the sticky flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_evt_i | input | 3 | Device event pulses: bus reset, receive error, resume |
| ep_irq_i | input | 16 | Endpoint interrupt summary levels |
| reg_addr_i | input | 2 | Register address: 0 source, 1 mask |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, loaded one cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case is an event pulse that lands in the very cycle of a clearing read while another flag is already pending. The stimulus first latches the receive-error flag. It then raises the bus-reset pulse in the same cycle that it drives the read strobe. It checks that this read returns only the older flag, that the next read returns only the bus-reset flag, and that a third read returns zero. The table-driven part combines event pulses, endpoint levels and masks so that `irq_o` is exercised with matching and non-matching enables.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SRC  = 2'd0,
    SEL_MASK = 2'd1
  } reg_sel_e;

  localparam int unsigned EVT_BUS_RESET = 0;
  localparam int unsigned EVT_RX_ERR    = 1;
  localparam int unsigned EVT_RESUME    = 2;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int unsigned NUM_DEV = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_DEV-1:0] lat_o
);
  logic [NUM_DEV-1:0] lat_q;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bit
    // set wins over clear so a coincident event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          lat_q[i] <= 1'b0;
      else if (evt_i[i])    lat_q[i] <= 1'b1;
      else if (clr_i)       lat_q[i] <= 1'b0;
    end
  end

  assign lat_o = lat_q;

  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((lat_q & $past(evt_i)) == $past(evt_i)));
  // R5
  clr_keeps_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lat_q == $past(evt_i)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VALID_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam logic [DATA_W-1:0] VALID_BITS = {{(DATA_W-VALID_W){1'b0}}, {VALID_W{1'b1}}};

  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & VALID_BITS;
  end

  assign mask_o = mask_q;

  // R7
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    unique case (addr_i)
      SEL_SRC:  rdata_d = src_i;
      SEL_MASK: rdata_d = mask_i;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == SEL_SRC) |=> (rdata_q[DATA_W-1:DATA_W-2] == 2'b00));
  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_EP  = 16,
  parameter int unsigned NUM_DEV = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] dev_evt_i,
  input  logic [NUM_EP-1:0]  ep_irq_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  localparam int unsigned DEV_LSB = NUM_EP;
  localparam int unsigned VALID_W = NUM_EP + NUM_DEV;

  logic               src_clr;
  logic               mask_wr;
  logic [NUM_DEV-1:0] dev_lat;
  logic [DATA_W-1:0]  mask;
  logic [DATA_W-1:0]  src_view;

  assign src_clr = reg_rd_i && (reg_addr_i == SEL_SRC);
  assign mask_wr = reg_wr_i && (reg_addr_i == SEL_MASK);

  irq_evt_latch #(.NUM_DEV(NUM_DEV)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (dev_evt_i),
    .clr_i  (src_clr),
    .lat_o  (dev_lat)
  );

  irq_mask_reg #(.DATA_W(DATA_W), .VALID_W(VALID_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mask_wr),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask)
  );

  always_comb begin
    src_view = '0;
    src_view[NUM_EP-1:0] = ep_irq_i;
    src_view[DEV_LSB +: NUM_DEV] = dev_lat;
  end

  irq_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .src_i   (src_view),
    .mask_i  (mask),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o = |(src_view & mask);

  // R9
  no_enable_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
  // R10
  no_side_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_clr && !(|dev_evt_i)) |=> $stable(dev_lat));
  // R8
  ep_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ep_irq_i & mask[NUM_EP-1:0])) |-> irq_o);
endmodule

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  dev_evt = '0;
  logic [15:0] ep_irq = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  irq_agg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .dev_evt_i(dev_evt), .ep_irq_i(ep_irq),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // stimulus: endpoint levels, event pulse, mask, expected irq
  typedef struct packed {
    logic [15:0] ep;
    logic [2:0]  evt;
    logic [31:0] mask;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'h0001, 3'b000, 32'h0000_0001, 1'b1},
    '{16'h8000, 3'b000, 32'h0000_0001, 1'b0},
    '{16'h0000, 3'b001, 32'h0001_0000, 1'b1},
    '{16'h0000, 3'b110, 32'h0001_0000, 1'b0},
    '{16'h00F0, 3'b100, 32'h0004_0000, 1'b1},
    '{16'h0A00, 3'b010, 32'h0000_0500, 1'b0},
    '{16'h0000, 3'b000, 32'hFFFF_FFFF, 1'b0}
  };

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // read; optional event pulse driven in the read cycle
  task automatic read_reg(logic [1:0] a, logic [2:0] evt_in_rd);
    @(negedge clk);
    addr = a; rd = 1'b1; dev_evt = evt_in_rd;
    @(negedge clk);
    rd = 1'b0; dev_evt = '0;
  endtask

  task automatic pulse_evt(logic [2:0] e);
    @(negedge clk);
    dev_evt = e;
    @(negedge clk);
    dev_evt = '0;
  endtask

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2 + 2);
    chk1("R1 irq in reset", irq, 1'b0);
    chk32("R1 rdata in reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    read_reg(2'd1, 3'b000);
    chk32("R1 mask after reset", rdata, 32'h0);
    read_reg(2'd0, 3'b000);
    chk32("R1 source after reset", rdata, 32'h0);

    // table walk: R2 R3 R4 R8 R9
    for (int i = 0; i < 7; i++) begin
      write_reg(2'd1, VECS[i].mask);
      @(negedge clk);
      ep_irq = VECS[i].ep;
      dev_evt = VECS[i].evt;
      @(negedge clk);
      dev_evt = '0;
      chk1($sformatf("R8 R9 irq vector %0d", i), irq, VECS[i].exp_irq);
      read_reg(2'd0, 3'b000);
      chk32($sformatf("R2 R3 source vector %0d", i), rdata,
            {13'h0, VECS[i].evt, VECS[i].ep});
      ep_irq = '0;
      read_reg(2'd0, 3'b000);
      chk32($sformatf("R4 R6 cleared vector %0d", i), rdata, 32'h0);
    end

    // R7 mask keeps only bits 18:0
    write_reg(2'd1, 32'hFFFF_FFFF);
    read_reg(2'd1, 3'b000);
    chk32("R7 mask readback", rdata, 32'h0007_FFFF);

    // R5 event coincident with the clearing read
    pulse_evt(3'b010);
    read_reg(2'd0, 3'b001);
    chk32("R5 read excludes coincident event", rdata, 32'h0002_0000);
    chk1("R5 irq stays up for pending event", irq, 1'b1);
    read_reg(2'd0, 3'b000);
    chk32("R5 coincident event kept", rdata, 32'h0001_0000);
    read_reg(2'd0, 3'b000);
    chk32("R4 all cleared", rdata, 32'h0);

    // R10 write to source and read of mask do not clear
    pulse_evt(3'b100);
    write_reg(2'd0, 32'hFFFF_FFFF);
    read_reg(2'd1, 3'b000);
    chk32("R10 mask read value", rdata, 32'h0007_FFFF);
    read_reg(2'd0, 3'b000);
    chk32("R10 flag survives", rdata, 32'h0004_0000);

    // R8 endpoint level reaches irq without an edge
    write_reg(2'd1, 32'h0000_0008);
    @(negedge clk);
    ep_irq = 16'h0008;
    #1;
    chk1("R8 same-cycle endpoint irq", irq, 1'b1);
    ep_irq = 16'h0000;
    #1;
    chk1("R6 R8 endpoint drop", irq, 1'b0);

    // R9 masked event latched but silent
    write_reg(2'd1, 32'h0000_0000);
    pulse_evt(3'b001);
    chk1("R9 masked event no irq", irq, 1'b0);
    read_reg(2'd0, 3'b000);
    chk32("R9 masked event readable", rdata, 32'h0001_0000);

    // R6 endpoint level not held
    ep_irq = 16'h0004;
    read_reg(2'd0, 3'b000);
    chk32("R6 level seen", rdata, 32'h0000_0004);
    ep_irq = 16'h0000;
    read_reg(2'd0, 3'b000);
    chk32("R6 level gone", rdata, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule